// File: doc/BRIEF.md
# Register-Indirect Load Sequencer

This block carries out one operation: it reads a memory word at an address that sits in a register, and writes that word into a register. A small register file, an address register and a data register share one internal bus. A step counter allows only one driver on that bus per step. The operation has three steps. First, the source register drives its contents as the memory address and the read request goes up. Second, the block waits on the memory's completion acknowledge and captures the memory data lines. Third, the captured word crosses the internal bus into the destination register.

The memory side is a simple request and acknowledge pair. The address and the read request stay steady for as many cycles as the memory needs. The word is taken on the first cycle in which the acknowledge is seen high, and the request drops right after. Surrounding logic loads registers through a load port and reads them back through a peek port.

Top module: `indload_seq`

## Requirements
- R1: When `rst_n` is low at a rising edge, the following are cleared: `mem_read`, `mem_addr`, `busy`, `done`, the data register and every register-file entry. This holds mid-sequence too.
- R2: `start` sampled high while idle makes `busy` high after that edge. One edge later, `mem_addr` equals the source register's contents and `mem_read` is 1.
- R3: While `mem_mfc` stays low in the wait step, `mem_read` stays 1, `mem_addr` holds and `done` stays 0, with no upper limit on the wait.
- R4: On the first edge at which `mem_mfc` is sampled high in the wait step, `mem_data` is captured and `mem_read` is 0 after that edge.
- R5: At the edge after the capture, the destination register receives the captured word. `done` is 1 for exactly the following cycle, and `busy` is 0 in that same cycle.
- R6: Values on `mem_data` while `mem_mfc` is low have no effect on the word delivered.
- R7: `start` while `busy` is ignored: the address does not change and no second read follows.
- R8: Source and destination may be the same register; it ends up holding the memory word.
- R9: `mem_mfc` high while idle has no effect: `busy`, `mem_read` and `done` stay 0.
- R10: `ld_en` writes `ld_data` into entry `ld_sel` at the edge, and `peek_data` shows entry `peek_sel` combinationally.
- R11: `src_sel` and `dst_sel` are captured at the accepted `start`. Changes to them later in the sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load when idle |
| src_sel | input | IDX_W | Register holding the address |
| dst_sel | input | IDX_W | Register receiving the word |
| ld_en | input | 1 | Register-file load strobe |
| ld_sel | input | IDX_W | Register-file load index |
| ld_data | input | W | Register-file load value |
| peek_sel | input | IDX_W | Register-file read-back index |
| peek_data | output | W | Register-file read-back value |
| mem_addr | output | W | Address register to memory |
| mem_read | output | 1 | Read request |
| mem_data | input | W | Memory data lines |
| mem_mfc | input | 1 | Memory function completed |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The main operation runs from a vector table that varies several things: register pairs, addresses (zero, all ones, top bit alone), data words, and acknowledge delays from zero up to twenty cycles. A zero delay shows that the acknowledge is taken on the first wait cycle, and a long delay shows that the wait has no limit. The data lines carry the complement of the word until the acknowledge arrives, so any early capture gives a wrong destination value. The select inputs change right after start in every run, which separates captured indices from live ones. Directed cases cover these situations: equal source and destination, acknowledge while idle, start during the wait, and reset during the wait.

// File: rtl/indload_pkg.sv
`timescale 1ns/1ps
// Shared types for the register-indirect load sequencer.
// Assumes: one internal bus with two possible drivers (register file, data register).
package indload_pkg;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_ADDR = 2'd1,
        STEP_WAIT = 2'd2,
        STEP_XFER = 2'd3
    } step_e;

    // Per-step control strobes decoded from the step counter.
    typedef struct packed {
        logic rf_oe;       // register file drives bus
        logic mar_ld;      // address register loads from bus
        logic rd_set;      // raise read request
        logic mdr_ext_ld;  // data register loads from memory lines
        logic rd_clr;      // drop read request
        logic mdr_oe;      // data register drives bus
        logic rf_we;       // register file loads from bus
    } ctl_t;

    localparam int BUS_SRCS = 2;
    localparam int SRC_RF   = 0;
    localparam int SRC_MDR  = 1;

endpackage

// File: rtl/indload_ctrl.sv
`timescale 1ns/1ps
// Step counter and control decode.
// Does: walks idle -> address -> wait -> transfer -> idle, holding in wait
// until the completion acknowledge, and pulses done after the write step.
// Assumes: mfc is synchronous to clk (synchronised outside if needed).
module indload_ctrl
    import indload_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  mfc,
    output step_e step,
    output ctl_t  ctl,
    output logic  done
);

    // Advance the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= STEP_IDLE;
        end else begin
            case (step)
                STEP_IDLE: if (start) step <= STEP_ADDR;
                STEP_ADDR: step <= STEP_WAIT;
                STEP_WAIT: if (mfc) step <= STEP_XFER;
                STEP_XFER: step <= STEP_IDLE;
                default:   step <= STEP_IDLE;
            endcase
        end
    end

    // Completion pulse in the cycle after the destination write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (step == STEP_XFER);
        end
    end

    // Decode the step into bus and register strobes.
    always_comb begin
        ctl = '0;
        case (step)
            STEP_ADDR: begin
                ctl.rf_oe  = 1'b1;
                ctl.mar_ld = 1'b1;
                ctl.rd_set = 1'b1;
            end
            STEP_WAIT: begin
                ctl.mdr_ext_ld = mfc;
                ctl.rd_clr     = mfc;
            end
            STEP_XFER: begin
                ctl.mdr_oe = 1'b1;
                ctl.rf_we  = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_WAIT && !mfc) |=> (step == STEP_WAIT)); // R3
    AST_ADVANCE_ON_MFC: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_WAIT && mfc) |=> (step == STEP_XFER)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_IDLE_MFC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_IDLE && !start) |=> (step == STEP_IDLE)); // R9

endmodule

// File: rtl/indload_bus.sv
`timescale 1ns/1ps
// Shared internal bus.
// Does: ORs the enabled drivers; reads zero when no driver is enabled.
// Assumes: at most one out-enable per cycle (checked below).
module indload_bus #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      oe,
    input  logic [N-1:0][W-1:0] drv,
    output logic [W-1:0]      bus
);

    // Merge gated drivers onto the bus.
    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            if (oe[i]) bus = bus | drv[i];
        end
    end

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oe)); // R5

endmodule

// File: rtl/indload_regfile.sv
`timescale 1ns/1ps
// Small register file.
// Does: one bus read port, one peek port, a sequence write port that takes
// priority over the external load port in the same cycle.
// Assumes: NREGS is a power of two so every index is in range.
module indload_regfile #(
    parameter int NREGS = 8,
    parameter int W     = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [W-1:0]     ld_data,
    input  logic [IDX_W-1:0] peek_idx,
    output logic [W-1:0]     peek_data
);

    logic [W-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        // Update one entry: sequence write first, then external load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && wr_idx == IDX_W'(g)) begin
                regs[g] <= wr_data;
            end else if (ld_en && ld_idx == IDX_W'(g)) begin
                regs[g] <= ld_data;
            end
        end
    end

    // Combinational read ports.
    assign rd_data   = regs[rd_idx];
    assign peek_data = regs[peek_idx];

    AST_SEQ_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(wr_idx)] == $past(wr_data))); // R5

endmodule

// File: rtl/indload_memif.sv
`timescale 1ns/1ps
// Memory-side registers.
// Does: holds the address register, the data register and the read request.
// Assumes: mdr_ext_ld and rd_clr come only in the wait step with mfc high.
module indload_memif
    import indload_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctl_t         ctl,
    input  logic [W-1:0] bus,
    input  logic [W-1:0] mem_data,
    output logic [W-1:0] mar,
    output logic [W-1:0] mdr,
    output logic         read
);

    // Address register loads from the internal bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
        end else if (ctl.mar_ld) begin
            mar <= bus;
        end
    end

    // Data register loads from the memory data lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr <= '0;
        end else if (ctl.mdr_ext_ld) begin
            mdr <= mem_data;
        end
    end

    // Read request raised with the address, dropped on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read <= 1'b0;
        end else if (ctl.rd_set) begin
            read <= 1'b1;
        end else if (ctl.rd_clr) begin
            read <= 1'b0;
        end
    end

    AST_MDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mdr_ext_ld |=> (mdr == $past(mem_data))); // R4
    AST_READ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rd_clr |=> !read); // R4
    AST_MAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (read && !ctl.rd_clr) |=> $stable(mar)); // R3
    AST_MDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.mdr_ext_ld && !ctl.mar_ld) |=> $stable(mdr)); // R6

endmodule

// File: rtl/indload_seq.sv
`timescale 1ns/1ps
// Register-indirect load sequencer (top).
// Does: on start, reads memory at the address held in register src_sel and
// writes the word into register dst_sel over one shared internal bus.
// Assumes: mem_mfc is synchronous; mem_data is valid whenever mem_mfc is high.
module indload_seq
    import indload_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int W     = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] src_sel,
    input  logic [IDX_W-1:0] dst_sel,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_sel,
    input  logic [W-1:0]     ld_data,
    input  logic [IDX_W-1:0] peek_sel,
    output logic [W-1:0]     peek_data,
    output logic [W-1:0]     mem_addr,
    output logic             mem_read,
    input  logic [W-1:0]     mem_data,
    input  logic             mem_mfc,
    output logic             busy,
    output logic             done
);

    step_e                          step;
    ctl_t                           ctl;
    logic [IDX_W-1:0]               src_q;
    logic [IDX_W-1:0]               dst_q;
    logic [W-1:0]                   rf_rd;
    logic [W-1:0]                   mdr;
    logic [W-1:0]                   bus;
    logic [BUS_SRCS-1:0]            bus_oe;
    logic [BUS_SRCS-1:0][W-1:0]     bus_drv;

    // Capture register indices when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (step == STEP_IDLE && start) begin
            src_q <= src_sel;
            dst_q <= dst_sel;
        end
    end

    assign busy = (step != STEP_IDLE);

    indload_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .mfc   (mem_mfc),
        .step  (step),
        .ctl   (ctl),
        .done  (done)
    );

    indload_regfile #(.NREGS(NREGS), .W(W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (src_q),
        .rd_data   (rf_rd),
        .we        (ctl.rf_we),
        .wr_idx    (dst_q),
        .wr_data   (bus),
        .ld_en     (ld_en),
        .ld_idx    (ld_sel),
        .ld_data   (ld_data),
        .peek_idx  (peek_sel),
        .peek_data (peek_data)
    );

    // Bus driver assignment.
    always_comb begin
        bus_oe           = '0;
        bus_drv          = '0;
        bus_oe[SRC_RF]   = ctl.rf_oe;
        bus_oe[SRC_MDR]  = ctl.mdr_oe;
        bus_drv[SRC_RF]  = rf_rd;
        bus_drv[SRC_MDR] = mdr;
    end

    indload_bus #(.W(W), .N(BUS_SRCS)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .oe    (bus_oe),
        .drv   (bus_drv),
        .bus   (bus)
    );

    indload_memif #(.W(W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .bus      (bus),
        .mem_data (mem_data),
        .mar      (mem_addr),
        .mdr      (mdr),
        .read     (mem_read)
    );

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2
    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(step == STEP_IDLE)) |=> $stable(src_q)); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5

endmodule

// File: tb/sim_indload_seq.sv
`timescale 1ns/1ps
module sim_indload_seq;

    localparam int NREGS = 8;
    localparam int W     = 16;
    localparam int IDX_W = 3;

    typedef struct packed {
        logic [2:0]  src;
        logic [2:0]  dst;
        logic [15:0] addr;
        logic [15:0] word;
        logic [7:0]  waits;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd1, 3'd2, 16'h0040, 16'hBEEF, 8'd0},
        '{3'd3, 3'd5, 16'h1234, 16'h5A5A, 8'd1},
        '{3'd0, 3'd7, 16'hFFFF, 16'h0001, 8'd3},
        '{3'd6, 3'd4, 16'h8000, 16'hFFFF, 8'd7},
        '{3'd7, 3'd0, 16'h0000, 16'h7E81, 8'd20},
        '{3'd4, 3'd1, 16'h00A5, 16'h0000, 8'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [IDX_W-1:0] src_sel = '0;
    logic [IDX_W-1:0] dst_sel = '0;
    logic             ld_en = 1'b0;
    logic [IDX_W-1:0] ld_sel = '0;
    logic [W-1:0]     ld_data = '0;
    logic [IDX_W-1:0] peek_sel = '0;
    logic [W-1:0]     peek_data;
    logic [W-1:0]     mem_addr;
    logic             mem_read;
    logic [W-1:0]     mem_data = '0;
    logic             mem_mfc = 1'b0;
    logic             busy;
    logic             done;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    indload_seq #(.NREGS(NREGS), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_sel(src_sel), .dst_sel(dst_sel),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .peek_sel(peek_sel), .peek_data(peek_data),
        .mem_addr(mem_addr), .mem_read(mem_read),
        .mem_data(mem_data), .mem_mfc(mem_mfc),
        .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [2:0] idx, input logic [15:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = idx; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // One full load; poke raises start with other indices during the wait.
    task automatic run_seq(input logic [2:0] src, input logic [2:0] dst,
                           input logic [15:0] addr, input logic [15:0] word,
                           input int waits, input bit poke);
        @(negedge clk);
        start = 1'b1; src_sel = src; dst_sel = dst; peek_sel = dst;
        mem_mfc = 1'b0; mem_data = ~word;
        @(negedge clk);
        start = 1'b0; src_sel = ~src; dst_sel = ~dst;
        chk("R2 busy after start", 32'(busy), 32'd1);
        @(negedge clk);
        chk("R2 address from source", 32'(mem_addr), 32'(addr));
        chk("R2 read raised", 32'(mem_read), 32'd1);
        for (int i = 0; i < waits; i++) begin
            mem_data = ~word ^ 16'(i);
            if (poke) begin start = 1'b1; src_sel = src + 3'd1; end
            @(negedge clk);
            chk("R3 read held", 32'(mem_read), 32'd1);
            chk("R3 done low", 32'(done), 32'd0);
            chk(poke ? "R7 address held" : "R3 address held", 32'(mem_addr), 32'(addr));
        end
        start = 1'b0;
        mem_mfc = 1'b1; mem_data = word;
        @(negedge clk);
        mem_mfc = 1'b0; mem_data = ~word;
        chk("R4 read dropped", 32'(mem_read), 32'd0);
        chk("R4 done not yet", 32'(done), 32'd0);
        @(negedge clk);
        chk("R5 done pulse", 32'(done), 32'd1);
        chk("R5 busy cleared", 32'(busy), 32'd0);
        chk("R5 R6 R11 destination word", 32'(peek_data), 32'(word));
        @(negedge clk);
        chk("R5 done one cycle", 32'(done), 32'd0);
        chk(poke ? "R7 no second read" : "R5 idle read", 32'(mem_read), 32'd0);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 read", 32'(mem_read), 32'd0);
        chk("R1 addr", 32'(mem_addr), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        for (int r = 0; r < NREGS; r++) begin
            peek_sel = IDX_W'(r);
            #0.1;
            chk("R1 register cleared", 32'(peek_data), 32'd0);
        end
        rst_n = 1'b1;

        // R10: load and peek
        preload(3'd4, 16'h4444);
        peek_sel = 3'd4;
        #0.1;
        chk("R10 load visible", 32'(peek_data), 32'h4444);

        // Table of vectors
        for (int v = 0; v < 6; v++) begin
            preload(VECS[v].src, VECS[v].addr);
            run_seq(VECS[v].src, VECS[v].dst, VECS[v].addr, VECS[v].word,
                    int'(VECS[v].waits), 1'b0);
        end

        // R8: source equals destination
        preload(3'd5, 16'h0ABC);
        run_seq(3'd5, 3'd5, 16'h0ABC, 16'h1357, 2, 1'b0);
        chk("R8 same register", 32'(peek_data), 32'h1357);

        // R9: acknowledge while idle
        @(negedge clk);
        mem_mfc = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R9 busy stays low", 32'(busy), 32'd0);
            chk("R9 read stays low", 32'(mem_read), 32'd0);
            chk("R9 done stays low", 32'(done), 32'd0);
        end
        mem_mfc = 1'b0;

        // R7: start during wait is ignored
        preload(3'd1, 16'h0100);
        run_seq(3'd1, 3'd3, 16'h0100, 16'hC3C3, 4, 1'b1);

        // R1: reset during the wait step
        preload(3'd2, 16'h2222);
        @(negedge clk);
        start = 1'b1; src_sel = 3'd2; dst_sel = 3'd6;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R1 pre-reset read", 32'(mem_read), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 read after mid reset", 32'(mem_read), 32'd0);
        chk("R1 addr after mid reset", 32'(mem_addr), 32'd0);
        chk("R1 busy after mid reset", 32'(busy), 32'd0);
        peek_sel = 3'd2;
        #0.1;
        chk("R1 register after mid reset", 32'(peek_data), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule